// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is a single transmit DMA channel. It follows a chain of four-word buffer descriptors held in a word-addressed synchronous memory. Software places descriptors in memory, sets the ownership bit in each mode word, and writes the address of the first descriptor to the head-pointer input. The channel then reads each descriptor, streams the packet bytes on a valid/ready byte port, writes the mode word back with ownership cleared, reports the descriptor address through the completion pointer, and follows the link to the next descriptor.

When a descriptor's link is zero, the write-back also sets the end-of-queue bit and the channel goes idle. Software restarts it by writing the head pointer again. A descriptor found without ownership ends the chain with nothing sent. A teardown command aborts the channel at once. The abort is reported by loading a fixed marker value into the completion pointer, and software acknowledges it by writing that marker back.

Pointers are byte addresses whose two low bits are ignored. Memory word address = pointer bits [AW+1:2].

Top module: `dmach_engine`

## Requirements
- R1: Descriptor words relative to its word address: +0 next-descriptor pointer, +1 buffer byte address (word aligned), +3 mode word; the packet length is mode[10:0]; word +2 is never read.
- R2: A `hdp_wr` with a non-zero value starts processing at that descriptor only when `chan_en` is 1, the channel is idle and `td_done` is 0; otherwise the write is ignored, including while busy.
- R3: Packet bytes leave in address order, lowest byte lane of each word first, holding `out_valid` and `out_data` until `out_ready`; `out_last` marks the final byte; a zero-length descriptor sends no byte.
- R4: During a packet `out_port_en` equals mode[20] and `out_port` equals mode[18:16].
- R5: After a descriptor is sent, its mode word is rewritten with bit 29 (ownership) cleared, bit 28 (end of queue) set exactly when its next pointer is zero, and every other bit unchanged.
- R6: A non-zero next pointer makes the channel continue with that descriptor; a zero next pointer leaves the channel idle (`busy` low) until the head pointer is written again.
- R7: A descriptor whose mode bit 29 is clear when read is not sent, not written back and not reported; the channel goes idle.
- R8: Each handback loads `cp_q` with the descriptor's address, sets `cp_pend`, and raises `irq_pulse` for exactly one cycle.
- R9: A `cp_wr` whose value equals `cp_q` clears `cp_pend`; any other value leaves it set.
- R10: `td_req` stops the channel without writing back an unfinished descriptor. It loads `cp_q` with 0xFFFFFFFC and sets `cp_pend` and `td_done`. Head writes are ignored while `td_done` is set. Writing 0xFFFFFFFC to `cp_wr` clears `td_done` and `cp_pend`.
- R11: After reset the channel is idle with `out_valid`, memory strobes, `cp_q`, `cp_pend` and `td_done` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; gates head-pointer starts |
| hdp_wr | input | 1 | Head-pointer write strobe |
| hdp_wdata | input | 32 | Head descriptor byte address |
| cp_wr | input | 1 | Completion-pointer acknowledge strobe |
| cp_wdata | input | 32 | Acknowledge value |
| td_req | input | 1 | Teardown command pulse |
| mem_rd | output | 1 | Memory read strobe (data next cycle) |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Byte accepted by sink |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |
| out_port_en | output | 1 | Directed-output enable from the mode word |
| out_port | output | 3 | Destination port from the mode word |
| busy | output | 1 | Channel is processing descriptors |
| cp_q | output | 32 | Completion pointer |
| cp_pend | output | 1 | Completion awaiting acknowledge |
| td_done | output | 1 | Teardown complete, awaiting acknowledge |
| irq_pulse | output | 1 | One-cycle pulse per handed-back descriptor |

## Verification
On every cycle, the checker confirms these properties: a stalled byte stays stable until it is taken; the memory port never reads and writes in the same cycle; every write-back clears ownership; the interrupt is a single cycle and coincides with a pending completion; and the teardown flag always goes with the marker in the completion pointer. Other behaviour can only be seen across whole scenarios. This covers byte order and the last-byte mark, chain following, end-of-queue stall and restart, and refusal of unowned descriptors. It also covers head writes that are ignored while busy or disabled, and the exact mode words left in memory after teardown.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int LEN_W      = 11;
    localparam int BIT_SOP    = 31;
    localparam int BIT_EOP    = 30;
    localparam int BIT_OWN    = 29;
    localparam int BIT_EOQ    = 28;
    localparam int BIT_TDC    = 27;
    localparam int BIT_DIR_EN = 20;
    localparam int PORT_LSB   = 16;
    localparam int PORT_W     = 3;
    localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

    // word offsets inside one descriptor
    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 1;
    localparam int OFS_MODE = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_A0,     // read request for link word
        S_A1,     // capture link, request buffer word
        S_A2,     // capture buffer, request mode word
        S_A3,     // capture mode, decide
        S_LDW,    // request buffer data word
        S_CAPW,   // capture buffer data word
        S_SEND,   // stream bytes
        S_WB      // write mode word back
    } seq_st_t;

    typedef struct packed {
        logic [31:0] nxt;
        logic [31:0] bufp;
        logic [31:0] mode;
    } desc_t;

    function automatic logic [31:0] handback_mode(input logic [31:0] m,
                                                  input logic end_q);
        logic [31:0] r;
        r          = m;
        r[BIT_OWN] = 1'b0;
        r[BIT_EOQ] = end_q;
        return r;
    endfunction

endpackage

// File: rtl/dmach_bytes.sv
module dmach_bytes
    import dmach_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             load,
    input  logic [31:0]      word_in,
    input  logic             adv,
    output logic [7:0]       byte_out,
    output logic             is_last,
    output logic             word_end
);

    logic [31:0]      word_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            cnt_q  <= '0;
            len_q  <= '0;
        end else begin
            if (start) begin
                cnt_q <= '0;
                len_q <= len_in;
            end else if (adv) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            if (load) word_q <= word_in;
        end
    end

    assign byte_out = word_q[{cnt_q[1:0], 3'b000} +: 8];
    assign is_last  = (cnt_q == len_q - LEN_W'(1));
    assign word_end = (cnt_q[1:0] == 2'd3);

endmodule

// File: rtl/dmach_cpreg.sv
module dmach_cpreg
    import dmach_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        complete_evt,
    input  logic [31:0] complete_addr,
    input  logic        td_evt,
    input  logic        cp_wr,
    input  logic [31:0] cp_wdata,
    output logic [31:0] cp_q,
    output logic        cp_pend,
    output logic        td_done,
    output logic        irq_pulse
);

    logic ack_hit;
    assign ack_hit = cp_wr && (cp_wdata == cp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_q      <= '0;
            cp_pend   <= 1'b0;
            td_done   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= complete_evt;
            if (td_evt) begin
                cp_q    <= TD_MARK;
                cp_pend <= 1'b1;
                td_done <= 1'b1;
            end else if (complete_evt) begin
                cp_q    <= complete_addr;
                cp_pend <= 1'b1;
            end else if (ack_hit) begin
                cp_pend <= 1'b0;
                if (cp_wdata == TD_MARK) td_done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              hdp_wr,
    input  logic [31:0]       hdp_wdata,
    input  logic              td_req,
    input  logic              td_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_port_en,
    output logic [PORT_W-1:0] out_port,
    output logic              bu_start,
    output logic [LEN_W-1:0]  bu_len,
    output logic              bu_load,
    output logic              bu_adv,
    input  logic              bu_last,
    input  logic              bu_word_end,
    output logic              complete_evt,
    output logic [31:0]       complete_addr,
    output logic              td_evt,
    output logic              busy
);

    seq_st_t        st_q;
    desc_t          d_q;
    logic [31:0]    cur_q;
    logic [AW-1:0]  wptr_q;
    logic           td_pend_q;

    logic [AW-1:0]  dw;
    logic           start;
    logic           td_act;
    logic           owned;
    logic           nonempty;
    logic           hs;

    assign dw       = cur_q[AW+1:2];
    assign td_act   = (td_req || td_pend_q) && (st_q != S_WB);
    assign start    = hdp_wr && chan_en && (hdp_wdata != 32'd0) &&
                      (st_q == S_IDLE) && !td_done && !td_act;
    assign owned    = mem_rdata[BIT_OWN];
    assign nonempty = (mem_rdata[LEN_W-1:0] != '0);
    assign hs       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            d_q       <= '0;
            cur_q     <= '0;
            wptr_q    <= '0;
            td_pend_q <= 1'b0;
        end else begin
            td_pend_q <= td_req && (st_q == S_WB);
            if (td_act) begin
                st_q <= S_IDLE;
            end else begin
                unique case (st_q)
                    S_IDLE: if (start) begin
                        cur_q <= hdp_wdata;
                        st_q  <= S_A0;
                    end
                    S_A0: st_q <= S_A1;
                    S_A1: begin
                        d_q.nxt <= mem_rdata;
                        st_q    <= S_A2;
                    end
                    S_A2: begin
                        d_q.bufp <= mem_rdata;
                        st_q     <= S_A3;
                    end
                    S_A3: begin
                        d_q.mode <= mem_rdata;
                        wptr_q   <= d_q.bufp[AW+1:2];
                        if (!owned)        st_q <= S_IDLE;
                        else if (nonempty) st_q <= S_LDW;
                        else               st_q <= S_WB;
                    end
                    S_LDW:  st_q <= S_CAPW;
                    S_CAPW: st_q <= S_SEND;
                    S_SEND: if (hs) begin
                        if (bu_last) begin
                            st_q <= S_WB;
                        end else if (bu_word_end) begin
                            wptr_q <= wptr_q + AW'(1);
                            st_q   <= S_LDW;
                        end
                    end
                    S_WB: begin
                        if (d_q.nxt == 32'd0) begin
                            st_q <= S_IDLE;
                        end else begin
                            cur_q <= d_q.nxt;
                            st_q  <= S_A0;
                        end
                    end
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        mem_addr = dw;
        unique case (st_q)
            S_A1:         mem_addr = dw + AW'(OFS_BUF);
            S_A2, S_WB:   mem_addr = dw + AW'(OFS_MODE);
            S_LDW:        mem_addr = wptr_q;
            default:      mem_addr = dw + AW'(OFS_NEXT);
        endcase
    end

    assign mem_rd    = (st_q == S_A0) || (st_q == S_A1) ||
                       (st_q == S_A2) || (st_q == S_LDW);
    assign mem_wr    = (st_q == S_WB);
    assign mem_wdata = handback_mode(d_q.mode, d_q.nxt == 32'd0);

    assign out_valid   = (st_q == S_SEND);
    assign out_port_en = d_q.mode[BIT_DIR_EN];
    assign out_port    = d_q.mode[PORT_LSB +: PORT_W];

    assign bu_start = (st_q == S_A3) && owned && nonempty;
    assign bu_len   = mem_rdata[LEN_W-1:0];
    assign bu_load  = (st_q == S_CAPW);
    assign bu_adv   = hs;

    assign complete_evt  = mem_wr;
    assign complete_addr = cur_q;
    assign td_evt        = td_act;
    assign busy          = (st_q != S_IDLE);

    logic unused_bufp;
    assign unused_bufp = ^{d_q.bufp[31:AW+2], d_q.bufp[1:0], cur_q[1:0], cur_q[31:AW+2]};

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          hdp_wr,
    input  logic [31:0]   hdp_wdata,
    input  logic          cp_wr,
    input  logic [31:0]   cp_wdata,
    input  logic          td_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          out_port_en,
    output logic [2:0]    out_port,
    output logic          busy,
    output logic [31:0]   cp_q,
    output logic          cp_pend,
    output logic          td_done,
    output logic          irq_pulse
);

    logic             bu_start;
    logic [LEN_W-1:0] bu_len;
    logic             bu_load;
    logic             bu_adv;
    logic             bu_last;
    logic             bu_word_end;
    logic             complete_evt;
    logic [31:0]      complete_addr;
    logic             td_evt;

    dmach_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .hdp_wr       (hdp_wr),
        .hdp_wdata    (hdp_wdata),
        .td_req       (td_req),
        .td_done      (td_done),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_port_en  (out_port_en),
        .out_port     (out_port),
        .bu_start     (bu_start),
        .bu_len       (bu_len),
        .bu_load      (bu_load),
        .bu_adv       (bu_adv),
        .bu_last      (bu_last),
        .bu_word_end  (bu_word_end),
        .complete_evt (complete_evt),
        .complete_addr(complete_addr),
        .td_evt       (td_evt),
        .busy         (busy)
    );

    dmach_bytes u_bytes (
        .clk      (clk),
        .rst      (rst),
        .start    (bu_start),
        .len_in   (bu_len),
        .load     (bu_load),
        .word_in  (mem_rdata),
        .adv      (bu_adv),
        .byte_out (out_data),
        .is_last  (bu_last),
        .word_end (bu_word_end)
    );

    dmach_cpreg u_cp (
        .clk          (clk),
        .rst          (rst),
        .complete_evt (complete_evt),
        .complete_addr(complete_addr),
        .td_evt       (td_evt),
        .cp_wr        (cp_wr),
        .cp_wdata     (cp_wdata),
        .cp_q         (cp_q),
        .cp_pend      (cp_pend),
        .td_done      (td_done),
        .irq_pulse    (irq_pulse)
    );

    assign out_last = out_valid && bu_last;

endmodule

// File: rtl/dmach_engine_chk.sv
module dmach_engine_chk
    import dmach_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          td_req,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_last,
    input logic          busy,
    input logic [31:0]   cp_q,
    input logic          cp_pend,
    input logic          td_done,
    input logic          irq_pulse
);

    // R3: a stalled byte stays offered and unchanged unless torn down
    p_valid_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !td_req) |=> (out_valid && $stable(out_data)));

    // R3: last marker only on an offered byte
    p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R1: one memory access per cycle
    p_mem_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R5: write-back always returns ownership
    p_own_clear_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_wdata[BIT_OWN]);

    // R8: interrupt is a single-cycle pulse with a pending completion
    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);
    p_irq_pend_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> cp_pend);

    // R10: teardown flag comes with the marker in the completion pointer
    p_td_mark_r10: assert property (@(posedge clk) disable iff (rst)
        td_done |-> (cp_q == TD_MARK && !busy));

    // R6: an idle channel leaves the memory port quiet
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr && !out_valid));

    logic unused_chk;
    assign unused_chk = ^mem_addr;

endmodule

bind dmach_engine dmach_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .td_req   (td_req),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .busy     (busy),
    .cp_q     (cp_q),
    .cp_pend  (cp_pend),
    .td_done  (td_done),
    .irq_pulse(irq_pulse)
);

// File: tb/dmach_engine_tb.sv
`timescale 1ns/1ps
module dmach_engine_tb_top;

    localparam int AW = 10;
    localparam int MW = 1 << AW;
    localparam logic [31:0] OWN  = 32'h2000_0000;
    localparam logic [31:0] EOQ  = 32'h1000_0000;
    localparam logic [31:0] SE   = 32'hC000_0000;
    localparam logic [31:0] MARK = 32'hFFFF_FFFC;

    typedef struct packed {
        logic [10:0] len;
        logic        pen;
        logic [2:0]  port;
        logic [3:0]  stall;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{len: 11'd1,  pen: 1'b0, port: 3'd0, stall: 4'd0, seed: 8'h10},
        '{len: 11'd4,  pen: 1'b1, port: 3'd2, stall: 4'd0, seed: 8'h20},
        '{len: 11'd5,  pen: 1'b1, port: 3'd5, stall: 4'd2, seed: 8'hF0},
        '{len: 11'd13, pen: 1'b0, port: 3'd7, stall: 4'd3, seed: 8'h33},
        '{len: 11'd32, pen: 1'b1, port: 3'd1, stall: 4'd0, seed: 8'h80},
        '{len: 11'd61, pen: 1'b1, port: 3'd6, stall: 4'd5, seed: 8'hFE}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_en = 1'b0;
    logic hdp_wr = 1'b0;
    logic [31:0] hdp_wdata = '0;
    logic cp_wr = 1'b0;
    logic [31:0] cp_wdata = '0;
    logic td_req = 1'b0;
    logic mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic out_valid, out_last, out_port_en;
    logic out_ready = 1'b1;
    logic [7:0] out_data;
    logic [2:0] out_port;
    logic busy, cp_pend, td_done, irq_pulse;
    logic [31:0] cp_q;

    always #4 clk = ~clk;

    dmach_engine #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en),
        .hdp_wr(hdp_wr), .hdp_wdata(hdp_wdata),
        .cp_wr(cp_wr), .cp_wdata(cp_wdata), .td_req(td_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_port_en(out_port_en), .out_port(out_port),
        .busy(busy), .cp_q(cp_q), .cp_pend(cp_pend), .td_done(td_done),
        .irq_pulse(irq_pulse)
    );

    // memory model
    logic [31:0] mem [MW];
    logic        tb_we = 1'b0;
    logic [AW-1:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // sink monitor
    logic [7:0] rx_data [4096];
    logic       rx_last [4096];
    logic [3:0] rx_port [4096];
    int rx_n = 0;
    int irq_n = 0;
    int cyc = 0;
    int stall = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && out_valid && out_ready) begin
            rx_data[rx_n] <= out_data;
            rx_last[rx_n] <= out_last;
            rx_port[rx_n] <= {out_port_en, out_port};
            rx_n <= rx_n + 1;
        end
        if (!rst && irq_pulse) irq_n <= irq_n + 1;
    end
    always @(negedge clk)
        out_ready <= (stall == 0) ? 1'b1 : ((cyc % stall) != 0);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                            input logic [31:0] bp, input logic [31:0] mode);
        mem[a[AW+1:2]]     = nxt;
        mem[a[AW+1:2] + 1] = bp;
        mem[a[AW+1:2] + 2] = 32'hDEAD_BEEF;
        mem[a[AW+1:2] + 3] = mode;
    endtask

    task automatic fill_buf(input logic [31:0] bp, input int len, input logic [7:0] seed);
        for (int i = 0; i < (len + 3) / 4; i++) mem[bp[AW+1:2] + i] = '0;
        for (int i = 0; i < len; i++)
            mem[bp[AW+1:2] + i / 4][8 * (i % 4) +: 8] = seed + 8'(i);
    endtask

    task automatic write_hdp(input logic [31:0] v);
        @(negedge clk); hdp_wr = 1'b1; hdp_wdata = v;
        @(negedge clk); hdp_wr = 1'b0; hdp_wdata = '0;
    endtask

    task automatic ack(input logic [31:0] v);
        @(negedge clk); cp_wr = 1'b1; cp_wdata = v;
        @(negedge clk); cp_wr = 1'b0; cp_wdata = '0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 5000) begin @(negedge clk); k++; end
        @(negedge clk);
    endtask

    task automatic check_bytes(input string req, input int base, input int len,
                               input logic [7:0] seed, input int off);
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            if (rx_data[base + i] != seed + 8'(i)) bad++;
            if (rx_last[base + i] != (i == len - 1 && off == 0)) bad++;
        end
        chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    logic wd = 1'b0;

    initial begin
        fork
            begin : main_t
                for (int i = 0; i < MW; i++) mem[i] = '0;
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                // R11 reset state
                chk(!busy && !out_valid && !mem_rd && !mem_wr, "R11",
                    {busy, out_valid, mem_rd, mem_wr}, 0);
                chk(cp_q == 0 && !cp_pend && !td_done, "R11", cp_q, 0);
                chan_en = 1'b1;

                // table of single-descriptor packets
                for (int v = 0; v < NV; v++) begin
                    int base, irq0;
                    logic [31:0] mode;
                    mode = OWN | SE | (32'(VECS[v].pen) << 20) |
                           (32'(VECS[v].port) << 16) | 32'(VECS[v].len);
                    put_desc(32'h100, 0, 32'h400, mode);
                    fill_buf(32'h400, int'(VECS[v].len), VECS[v].seed);
                    stall = int'(VECS[v].stall);
                    base = rx_n; irq0 = irq_n;
                    write_hdp(32'h100);
                    wait_idle();
                    chk(rx_n - base == int'(VECS[v].len), "R3 count",
                        32'(rx_n - base), 32'(VECS[v].len));
                    check_bytes("R3 order/last", base, int'(VECS[v].len), VECS[v].seed, 0);
                    chk(rx_port[base] == {VECS[v].pen, VECS[v].port}, "R4",
                        32'(rx_port[base]), {VECS[v].pen, VECS[v].port});
                    chk(mem[64 + 3] == ((mode & ~OWN) | EOQ), "R5", mem[64 + 3],
                        (mode & ~OWN) | EOQ);
                    chk(cp_q == 32'h100 && cp_pend, "R8 cp", cp_q, 32'h100);
                    chk(irq_n - irq0 == 1, "R8 irq", 32'(irq_n - irq0), 1);
                    chk(!busy, "R6 idle", 32'(busy), 0);
                    ack(32'h104);
                    chk(cp_pend, "R9 wrong ack", 32'(cp_pend), 1);
                    ack(32'h100);
                    chk(!cp_pend, "R9 ack", 32'(cp_pend), 0);
                end
                stall = 0;

                // R6 / R1 two-descriptor chain
                begin
                    int base, irq0;
                    put_desc(32'h100, 32'h140, 32'h400, OWN | SE | 6);
                    put_desc(32'h140, 0, 32'h600, OWN | SE | 9);
                    fill_buf(32'h400, 6, 8'h40);
                    fill_buf(32'h600, 9, 8'h46);
                    base = rx_n; irq0 = irq_n;
                    write_hdp(32'h100);
                    wait_idle();
                    chk(rx_n - base == 15, "R6 chain count", 32'(rx_n - base), 15);
                    check_bytes("R1 chain bytes A", base, 6, 8'h40, 0);
                    check_bytes("R1 chain bytes B", base + 6, 9, 8'h46, 0);
                    chk(mem[64 + 3] == (SE | 6), "R5 no eoq", mem[64 + 3], SE | 6);
                    chk(mem[80 + 3] == (SE | EOQ | 9), "R5 eoq", mem[80 + 3], SE | EOQ | 9);
                    chk(cp_q == 32'h140 && irq_n - irq0 == 2, "R8 chain", cp_q, 32'h140);
                    ack(32'h140);
                end

                // R7 unowned descriptor
                begin
                    int base, irq0;
                    put_desc(32'h180, 0, 32'h400, SE | 8);
                    base = rx_n; irq0 = irq_n;
                    write_hdp(32'h180);
                    wait_idle();
                    chk(rx_n == base && irq_n == irq0, "R7 no send", 32'(rx_n - base), 0);
                    chk(mem[96 + 3] == (SE | 8), "R7 untouched", mem[96 + 3], SE | 8);
                    chk(!cp_pend && cp_q == 32'h140, "R7 no cp", cp_q, 32'h140);
                end

                // R3 zero length
                begin
                    int base, irq0;
                    put_desc(32'h100, 0, 32'h400, OWN | SE);
                    base = rx_n; irq0 = irq_n;
                    write_hdp(32'h100);
                    wait_idle();
                    chk(rx_n == base, "R3 zero len", 32'(rx_n - base), 0);
                    chk(mem[64 + 3] == (SE | EOQ) && irq_n - irq0 == 1, "R5 zero len wb",
                        mem[64 + 3], SE | EOQ);
                    ack(32'h100);
                end

                // R2 disabled and zero head writes
                put_desc(32'h100, 0, 32'h400, OWN | SE | 4);
                chan_en = 1'b0;
                write_hdp(32'h100);
                chk(!busy, "R2 disabled", 32'(busy), 0);
                chan_en = 1'b1;
                write_hdp(32'h0);
                chk(!busy, "R2 zero ptr", 32'(busy), 0);

                // R2 head write while busy ignored, then R6 restart after eoq
                begin
                    int base;
                    put_desc(32'h100, 0, 32'h400, OWN | SE | 40);
                    fill_buf(32'h400, 40, 8'h01);
                    put_desc(32'h1C0, 0, 32'h700, OWN | SE | 4);
                    fill_buf(32'h700, 4, 8'hA0);
                    stall = 3;
                    base = rx_n;
                    write_hdp(32'h100);
                    repeat (6) @(negedge clk);
                    write_hdp(32'h1C0);
                    wait_idle();
                    chk(rx_n - base == 40, "R2 busy ignore", 32'(rx_n - base), 40);
                    chk(mem[112 + 3] == (OWN | SE | 4), "R2 busy desc kept",
                        mem[112 + 3], OWN | SE | 4);
                    ack(32'h100);
                    base = rx_n;
                    write_hdp(32'h1C0);
                    wait_idle();
                    check_bytes("R6 restart", base, 4, 8'hA0, 0);
                    chk(rx_n - base == 4, "R6 restart count", 32'(rx_n - base), 4);
                    ack(32'h1C0);
                    stall = 0;
                end

                // R10 teardown mid-packet
                begin
                    int base;
                    put_desc(32'h100, 0, 32'h400, OWN | SE | 60);
                    fill_buf(32'h400, 60, 8'h55);
                    base = rx_n;
                    write_hdp(32'h100);
                    repeat (10) @(negedge clk);
                    td_req = 1'b1; @(negedge clk); td_req = 1'b0;
                    @(negedge clk);
                    chk(!busy && !out_valid, "R10 stop", 32'(busy), 0);
                    chk(rx_n - base < 60, "R10 partial", 32'(rx_n - base), 60);
                    chk(mem[64 + 3] == (OWN | SE | 60), "R10 no wb", mem[64 + 3],
                        OWN | SE | 60);
                    chk(cp_q == MARK && td_done && cp_pend, "R10 marker", cp_q, MARK);
                    write_hdp(32'h100);
                    chk(!busy, "R10 head blocked", 32'(busy), 0);
                    ack(MARK);
                    chk(!td_done && !cp_pend, "R10 ack", {td_done, cp_pend}, 0);
                    base = rx_n;
                    write_hdp(32'h100);
                    wait_idle();
                    chk(rx_n - base == 60, "R10 resume", 32'(rx_n - base), 60);
                end
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule